// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches virtual-to-physical page translations in four ways of thirty-two sets. A lookup presents a 22-bit virtual page number and the current 8-bit address-space identifier. The set index is taken from page-number bits [6:2]. Each way's entry at that set is compared against the request. One cycle later the block reports one of three outcomes. A hit returns the physical page and attribute bits. An invalid result means a tag matched but the entry's valid bit was clear. A miss means no tag matched. The block also reports which way matched.

Refills go through two staging words. The upper word holds the page number and the identifier. The lower word holds the physical page number and the attribute bits. A load command copies both staging words into the indexed set, at the way named by a replacement-way register. Software may write that register ahead of the load to choose the victim. The block itself writes the matching way into the register whenever a lookup ends invalid, so a handler can refill the same slot.

Entries may cover a 1 KB or a 4 KB page. A per-entry size bit narrows the compare for large pages. A per-entry shared bit waives the identifier compare.

Top module: `tlb_sa`

## Requirements
- R1: Asynchronous reset drives `rc_o` to 0 and `res_vld_o` to 0. Reset also zeroes every stored entry, including its valid bit. A lookup of a nonzero tag after reset therefore misses. A lookup of page 0 with identifier 0 reports invalid on way 0.
- R2: A lookup is granted when `lk_req_i` is high and `ld_i` is low. Its result appears on `res_vld_o` and the `res_*` outputs in the following cycle. The result codes are 0 for miss, 1 for hit and 2 for invalid. The set index is `lk_vpn_i[6:2]`.
- R3: A hit needs a tag match on an entry whose valid bit is 1. It returns code 1, the entry's physical page on `res_ppn_o`, and its attribute bits on `res_attr_o`. The attribute bits are [6:5] protection key, [4] size, [3] cacheable, [2] dirty, [1] shared and [0] valid.
- R4: A size bit of 0 marks a 1 KB page, and all 22 page-number bits must match. A size bit of 1 marks a 4 KB page, and page-number bits [1:0] are ignored.
- R5: The entry's identifier must equal `lk_asid_i`, unless the entry's shared bit is 1.
- R6: A tag match on an entry whose valid bit is 0 gives code 2 and reports that way on `res_way_o`. The physical page and attribute outputs then read zero.
- R7: An invalid result writes its way into the replacement-way register. The new value shows on `rc_o` in the same cycle as the result.
- R8: A miss gives code 0 and way 0, with zero page and attribute outputs. A miss leaves `rc_o` unchanged.
- R9: When several ways match, the lowest-numbered one is reported.
- R10: `hi_we_i` and `lo_we_i` write the staging words. The upper word is laid out as [29:8] page number and [7:0] identifier. The lower word is laid out as [28:7] physical page and [6:0] attributes. `ld_i` copies the staging words into way `rc_o` at set upper[14:10], which is page-number bits [6:2]. The copy uses the staging contents held before that edge.
- R11: `rc_we_i` loads `rc_wdata_i` into the replacement-way register, visible on the next cycle. A software write overrides a capture from an invalid result in the same cycle. The value then chooses the way for a later load.
- R12: When `ld_i` and `lk_req_i` are high together, the load is performed and `lk_gnt_o` is low. No result follows in the next cycle. A lookup in the cycle after that sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_we_i | input | 1 | Write upper staging word |
| hi_wdata_i | input | 30 | Upper staging data: page number and identifier |
| lo_we_i | input | 1 | Write lower staging word |
| lo_wdata_i | input | 29 | Lower staging data: physical page and attributes |
| ld_i | input | 1 | Load staging words into the buffer |
| rc_we_i | input | 1 | Software write of the replacement way |
| rc_wdata_i | input | 2 | Replacement way value |
| rc_o | output | 2 | Current replacement way |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | 22 | Lookup page number |
| lk_asid_i | input | 8 | Current address-space identifier |
| lk_gnt_o | output | 1 | Lookup accepted this cycle |
| res_vld_o | output | 1 | Result valid |
| res_kind_o | output | 2 | 0 miss, 1 hit, 2 invalid |
| res_way_o | output | 2 | Matching way |
| res_ppn_o | output | 22 | Physical page on a hit |
| res_attr_o | output | 7 | Attribute bits on a hit |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a load and a lookup. The bench raises `ld_i` and `lk_req_i` together. It expects `lk_gnt_o` low, no result in the next cycle, and a hit on the new entry in the cycle after. The second pair is a software write of the replacement way and an invalid lookup that captures its way. The bench issues both at the same edge and expects `rc_o` to hold the software value, while the result still names the matched way. Random traffic over a small pool of page numbers mixes loads, lookups and way writes, and judges each outcome against a bench model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 22;
  localparam int ASID_W = 8;
  localparam int PPN_W  = 22;
  localparam int SZ_SHIFT = 2;   // 4 KB page drops this many low page bits

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
  } hi_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       pr;
    logic             sz;
    logic             c;
    logic             d;
    logic             sh;
    logic             v;
  } lo_t;

  typedef struct packed {
    hi_t hi;
    lo_t lo;
  } entry_t;

  localparam int HI_W   = $bits(hi_t);
  localparam int LO_W   = $bits(lo_t);
  localparam int ATTR_W = LO_W - PPN_W;

  typedef enum logic [1:0] {
    RES_MISS = 2'd0,
    RES_HIT  = 2'd1,
    RES_INV  = 2'd2
  } res_e;
endpackage

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int NUM_SETS = 32,
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  entry_t           wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output entry_t           rdata_o
);
  entry_t mem_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) mem_q[s] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];

  p_load_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/tlb_cmp.sv
module tlb_cmp
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  entry_t            ent_i [NUM_WAYS],
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_any_o,
  output logic [WAY_W-1:0]  way_o,
  output entry_t            ent_o
);
  logic [NUM_WAYS-1:0] match;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    logic tag_ok, asid_ok;
    always_comb begin
      if (ent_i[g].lo.sz)
        tag_ok = ent_i[g].hi.vpn[VPN_W-1:SZ_SHIFT] == vpn_i[VPN_W-1:SZ_SHIFT];
      else
        tag_ok = ent_i[g].hi.vpn == vpn_i;
      asid_ok = ent_i[g].lo.sh || (ent_i[g].hi.asid == asid_i);
    end
    assign match[g] = tag_ok && asid_ok;
  end

  // Lowest matching way wins
  always_comb begin
    way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  assign hit_any_o = |match;
  assign ent_o     = ent_i[way_o];

  p_lowest_way_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_any_o |-> (match & ((NUM_WAYS'(1) << way_o) - NUM_WAYS'(1))) == '0);
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 32,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int IDX_W = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_we_i,
  input  logic [HI_W-1:0]   hi_wdata_i,
  input  logic              lo_we_i,
  input  logic [LO_W-1:0]   lo_wdata_i,
  input  logic              ld_i,
  input  logic              rc_we_i,
  input  logic [WAY_W-1:0]  rc_wdata_i,
  output logic [WAY_W-1:0]  rc_o,
  input  logic              lk_req_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_gnt_o,
  output logic              res_vld_o,
  output logic [1:0]        res_kind_o,
  output logic [WAY_W-1:0]  res_way_o,
  output logic [PPN_W-1:0]  res_ppn_o,
  output logic [ATTR_W-1:0] res_attr_o
);
  hi_t              stg_hi_q;
  lo_t              stg_lo_q;
  logic [WAY_W-1:0] rc_q;
  entry_t           rd_ent [NUM_WAYS];
  entry_t           sel_ent;
  logic             hit_any;
  logic [WAY_W-1:0] hit_way;
  logic [IDX_W-1:0] ridx, widx;
  entry_t           wr_ent;

  // staging words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_hi_q <= '0;
      stg_lo_q <= '0;
    end else begin
      if (hi_we_i) stg_hi_q <= hi_t'(hi_wdata_i);
      if (lo_we_i) stg_lo_q <= lo_t'(lo_wdata_i);
    end
  end

  assign lk_gnt_o = lk_req_i && !ld_i;
  assign ridx     = lk_vpn_i[SZ_SHIFT +: IDX_W];
  assign widx     = stg_hi_q.vpn[SZ_SHIFT +: IDX_W];
  assign wr_ent   = '{hi: stg_hi_q, lo: stg_lo_q};

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_ways
    tlb_way #(.NUM_SETS(NUM_SETS)) i_way (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (ld_i && (rc_q == WAY_W'(g))),
      .widx_i  (widx),
      .wdata_i (wr_ent),
      .ridx_i  (ridx),
      .rdata_o (rd_ent[g])
    );
  end

  tlb_cmp #(.NUM_WAYS(NUM_WAYS)) i_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ent_i     (rd_ent),
    .vpn_i     (lk_vpn_i),
    .asid_i    (lk_asid_i),
    .hit_any_o (hit_any),
    .way_o     (hit_way),
    .ent_o     (sel_ent)
  );

  // result stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o  <= 1'b0;
      res_kind_o <= RES_MISS;
      res_way_o  <= '0;
      res_ppn_o  <= '0;
      res_attr_o <= '0;
    end else begin
      res_vld_o  <= lk_gnt_o;
      res_kind_o <= RES_MISS;
      res_way_o  <= '0;
      res_ppn_o  <= '0;
      res_attr_o <= '0;
      if (lk_gnt_o && hit_any) begin
        res_way_o <= hit_way;
        if (sel_ent.lo.v) begin
          res_kind_o <= RES_HIT;
          res_ppn_o  <= sel_ent.lo.ppn;
          res_attr_o <= sel_ent.lo[ATTR_W-1:0];
        end else begin
          res_kind_o <= RES_INV;
        end
      end
    end
  end

  // replacement way: software write beats capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  rc_q <= '0;
    else if (rc_we_i)                             rc_q <= rc_wdata_i;
    else if (lk_gnt_o && hit_any && !sel_ent.lo.v) rc_q <= hit_way;
  end

  assign rc_o = rc_q;

  p_kind_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o |-> res_kind_o != 2'd3);

  p_hit_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && res_kind_o == RES_HIT) |-> res_attr_o[0]);

  p_nohit_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && res_kind_o != RES_HIT) |-> (res_ppn_o == '0 && res_attr_o == '0));

  p_rc_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_vld_o && res_kind_o == RES_INV && !$past(rc_we_i)) |-> rc_o == res_way_o);

  p_rc_sw_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rc_we_i |=> rc_o == $past(rc_wdata_i));

  p_ld_blocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> !res_vld_o);
endmodule

// File: tb/test_tlb_sa.sv
module test_tlb_sa;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hi_we_i = 0, lo_we_i = 0, ld_i = 0, rc_we_i = 0, lk_req_i = 0;
  logic [29:0] hi_wdata_i = '0;
  logic [28:0] lo_wdata_i = '0;
  logic [1:0]  rc_wdata_i = '0;
  logic [21:0] lk_vpn_i = '0;
  logic [7:0]  lk_asid_i = '0;
  logic [1:0]  rc_o, res_kind_o, res_way_o;
  logic        lk_gnt_o, res_vld_o;
  logic [21:0] res_ppn_o;
  logic [6:0]  res_attr_o;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_sa i_tlb_sa (
    .clk_i(clk), .rst_ni(rst_ni),
    .hi_we_i(hi_we_i), .hi_wdata_i(hi_wdata_i),
    .lo_we_i(lo_we_i), .lo_wdata_i(lo_wdata_i),
    .ld_i(ld_i), .rc_we_i(rc_we_i), .rc_wdata_i(rc_wdata_i), .rc_o(rc_o),
    .lk_req_i(lk_req_i), .lk_vpn_i(lk_vpn_i), .lk_asid_i(lk_asid_i),
    .lk_gnt_o(lk_gnt_o), .res_vld_o(res_vld_o), .res_kind_o(res_kind_o),
    .res_way_o(res_way_o), .res_ppn_o(res_ppn_o), .res_attr_o(res_attr_o)
  );

  // bench model
  logic [29:0] m_hi [4][32];
  logic [28:0] m_lo [4][32];
  logic [29:0] m_shi;
  logic [28:0] m_slo;
  logic [1:0]  m_rc;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_look(input logic [21:0] vpn, input logic [7:0] asid,
      output logic [1:0] kind, output logic [1:0] way,
      output logic [21:0] ppn, output logic [6:0] attr);
    int idx = int'(vpn[6:2]);
    kind = 0; way = 0; ppn = 0; attr = 0;
    for (int w = 3; w >= 0; w--) begin
      logic [29:0] h = m_hi[w][idx];
      logic [28:0] l = m_lo[w][idx];
      logic tm = l[4] ? (h[29:10] == vpn[21:2]) : (h[29:8] == vpn);
      logic am = l[1] || (h[7:0] == asid);
      if (tm && am) begin
        way = 2'(w);
        kind = l[0] ? 2'd1 : 2'd2;
        ppn = l[0] ? l[28:7] : 22'd0;
        attr = l[0] ? l[6:0] : 7'd0;
      end
    end
  endfunction

  task automatic stage(input logic [29:0] h, input logic [28:0] l);
    hi_we_i = 1; lo_we_i = 1; hi_wdata_i = h; lo_wdata_i = l;
    @(posedge clk); #1;
    hi_we_i = 0; lo_we_i = 0;
    m_shi = h; m_slo = l;
  endtask

  task automatic load();
    ld_i = 1;
    @(posedge clk); #1;
    ld_i = 0;
    m_hi[m_rc][m_shi[14:10]] = m_shi;
    m_lo[m_rc][m_shi[14:10]] = m_slo;
  endtask

  task automatic set_rc(input logic [1:0] v);
    rc_we_i = 1; rc_wdata_i = v;
    @(posedge clk); #1;
    rc_we_i = 0;
    m_rc = v;
    chk(rc_o == v, "R11 rc write", rc_o, v);
  endtask

  task automatic lookup(input logic [21:0] vpn, input logic [7:0] asid,
                        input bit rcw, input logic [1:0] rcv, input string req);
    logic [1:0] ek, ew; logic [21:0] ep; logic [6:0] ea;
    model_look(vpn, asid, ek, ew, ep, ea);
    lk_req_i = 1; lk_vpn_i = vpn; lk_asid_i = asid;
    rc_we_i = rcw; rc_wdata_i = rcv;
    #1;
    chk(lk_gnt_o == 1'b1, {req, " R2 grant"}, lk_gnt_o, 1);
    @(posedge clk); #1;
    lk_req_i = 0; rc_we_i = 0;
    if (rcw) m_rc = rcv;
    else if (ek == 2'd2) m_rc = ew;
    chk(res_vld_o == 1'b1, {req, " R2 valid"}, res_vld_o, 1);
    chk(res_kind_o == ek, {req, " kind"}, res_kind_o, ek);
    chk(res_way_o == ew, {req, " R9 way"}, res_way_o, ew);
    chk(res_ppn_o == ep && res_attr_o == ea, {req, " R3 ppn/attr"},
        {res_ppn_o, res_attr_o}, {ep, ea});
    chk(rc_o == m_rc, {req, " R7 rc"}, rc_o, m_rc);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [21:0] va, vb, vc, vd, ve, pool [8];
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 32; s++) begin m_hi[w][s] = '0; m_lo[w][s] = '0; end
    m_shi = '0; m_slo = '0; m_rc = 0;
    void'($urandom(32'h5eed));
    #20;
    chk(rc_o == 2'd0 && res_vld_o == 1'b0, "R1 reset outputs", {rc_o, res_vld_o}, 0);
    @(negedge clk); rst_ni = 1;
    @(posedge clk); #1;

    // R1: cleared entries
    lookup(22'h2468C, 8'h03, 0, 0, "R1 miss after reset");
    lookup(22'h0, 8'h00, 0, 0, "R1 zero tag invalid");

    // R3 / R4 / R5 on a 1 KB private page
    va = 22'h12345;
    set_rc(2'd0);
    stage({va, 8'h01}, {22'h0ABCD, 7'b01_0_1_0_0_1});
    load();
    lookup(va, 8'h01, 0, 0, "R3 hit 1KB");
    lookup(va ^ 22'h1, 8'h01, 0, 0, "R4 1KB low bit miss");
    lookup(va, 8'h02, 0, 0, "R5 asid miss");

    // R4 / R5 on a 4 KB shared page
    vb = 22'h2A0F0;
    set_rc(2'd1);
    stage({vb, 8'h09}, {22'h1F00F, 7'b11_1_0_1_1_1});
    load();
    lookup(vb | 22'h3, 8'h77, 0, 0, "R4 R5 4KB shared hit");

    // R6 / R7 invalid entry in way 3
    vc = 22'h01F08;
    set_rc(2'd3);
    stage({vc, 8'h05}, {22'h00777, 7'b00_0_1_1_0_0});
    load();
    set_rc(2'd0);
    lookup(vc, 8'h05, 0, 0, "R6 R7 invalid way3");
    chk(rc_o == 2'd3, "R7 captured way", rc_o, 3);

    // R8 miss leaves rc
    lookup(vc ^ 22'h100, 8'h05, 0, 0, "R8 miss");
    chk(rc_o == 2'd3, "R8 rc unchanged", rc_o, 3);

    // R11 override in same cycle as invalid capture
    lookup(vc, 8'h05, 1, 2'd2, "R11 sw beats capture");
    chk(rc_o == 2'd2, "R11 override", rc_o, 2);

    // R9 lowest way among several
    vd = 22'h3C00C;
    stage({vd, 8'h04}, {22'h22222, 7'b00_0_0_0_0_1});
    load();
    set_rc(2'd1);
    stage({vd, 8'h04}, {22'h11111, 7'b00_0_0_0_0_1});
    load();
    lookup(vd, 8'h04, 0, 0, "R9 lowest of ways 1,2");
    chk(res_way_o == 2'd1 && res_ppn_o == 22'h11111, "R9 way1", res_way_o, 1);

    // R12 load and lookup in same cycle
    ve = 22'h0BEE4;
    set_rc(2'd2);
    stage({ve, 8'h06}, {22'h3ABCD, 7'b10_0_1_0_0_1});
    ld_i = 1; lk_req_i = 1; lk_vpn_i = ve; lk_asid_i = 8'h06;
    #1;
    chk(lk_gnt_o == 1'b0, "R12 grant low", lk_gnt_o, 0);
    @(posedge clk); #1;
    ld_i = 0; lk_req_i = 0;
    m_hi[2][ve[6:2]] = m_shi; m_lo[2][ve[6:2]] = m_slo;
    chk(res_vld_o == 1'b0, "R12 no result", res_vld_o, 0);
    lookup(ve, 8'h06, 0, 0, "R12 sees new entry");
    chk(res_kind_o == 2'd1 && res_way_o == 2'd2, "R12 hit way2", {res_kind_o, res_way_o}, 6);

    // R10 staging write during load uses old contents
    stage({22'h155A8, 8'h0A}, {22'h0F0F0, 7'b00_0_0_0_0_1});
    set_rc(2'd3);
    hi_we_i = 1; hi_wdata_i = {22'h2AA54, 8'h0A}; ld_i = 1;
    @(posedge clk); #1;
    hi_we_i = 0; ld_i = 0;
    m_hi[3][m_shi[14:10]] = m_shi; m_lo[3][m_shi[14:10]] = m_slo;
    m_shi = {22'h2AA54, 8'h0A};
    lookup(22'h155A8, 8'h0A, 0, 0, "R10 old stage loaded");
    chk(res_kind_o == 2'd1 && res_ppn_o == 22'h0F0F0, "R10 loaded value", res_ppn_o, 22'h0F0F0);

    // random traffic
    for (int i = 0; i < 8; i++) pool[i] = 22'($urandom);
    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom_range(0, 5));
      logic [21:0] v = pool[$urandom_range(0, 7)] ^ 22'($urandom_range(0, 3));
      logic [7:0]  a = 8'($urandom_range(1, 2));
      if (op < 3) begin
        lookup(v, a, 0, 0, "R3 random lookup");
      end else if (op == 3) begin
        set_rc(2'($urandom));
      end else if (op == 4) begin
        stage({v, a}, 29'($urandom));
        load();
      end else begin
        lookup(v, a, 1, 2'($urandom), "R11 random rc");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule